// File: doc/BRIEF.md
# Interlaced Raster Timing Counter

This block keeps the beam position of a video raster. A dot-clock enable steps a dot counter across each line; at the end of a line the line counter advances, and at the end of the frame it returns to zero. In interlaced operation, an odd/even field flag inverts at every frame wrap. Four programmable registers set the raster geometry:

- line and frame totals,
- vertical and horizontal sync lengths,
- the interlace enable,
- the front porch.

The back porch, the line that marks the start of a new frame and the length of the retrace zone are fixed by parameters.

Software or a neighbouring block reads a 14-bit sync-status word at any time. The word holds the current line, the field, and three flags: display active, horizontal sync inactive and vertical sync inactive. These flags are decoded one way on lines whose low bit equals the field flag and another way on the remaining lines. A one-cycle frame-start pulse and a retrace flag are also provided.

Top module: `raster_timer`

## Requirements
- R1: After reset the block holds 625 lines of 864 dots each, 5 vertical sync lines, a horizontal sync of 128 dots and a front porch of 1 dot. Interlace is off, and the dot counter, line counter and field are all 0.
- R2: The dot counter advances by one only in cycles where dot_en is high. When it is at dots-1 and dot_en is high, it returns to 0 and the line counter advances.
- R3: When the line counter is at lines-1 and wraps, it returns to 0. The field flag inverts at that moment if interlace is enabled, and never changes otherwise.
- R4: status[9:0] equals the current line and status[10] equals the field flag.
- R5: On a line whose bit 0 equals the field flag:
  - status[12] is 1 once the dot position is at least the horizontal sync width.
  - status[13] is 1 when the line is at least the vertical sync count.
  - status[11] is 1 when status[13] is 1 and the dot position is at least the front porch length.
- R6: On any other line:
  - status[12] is always 1.
  - status[13] is 1 when the line is at least the vertical sync count.
  - status[11] is 1 when status[13] is 1 and the dot position is below dots minus BACK_PORCH.
- R7: frame_start is high for exactly one cycle, the cycle after the line counter advances onto line FRAME_LINE.
- R8: in_retrace is high while the line is at least lines minus RETRACE_LINES.
- R9: A write to the total register sets the dot counter to 0 and clamps the line counter to the new lines-1. This write takes priority over dot_en in the same cycle.
- R10: The registers are selected by wr_sel as follows:
  - 0 is the totals register: lines-1 in bits 25:16 and dots-1 in bits 9:0.
  - 1 is the sync lengths register: the vertical sync line count in bits 11:8, and the horizontal sync width in bits 6:0, counted as (value+1)*2 dots.
  - 2 is the configuration register: interlace in bit 4.
  - 3 is the porch register: the front porch in bits 9:0, counted as value+1 dots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| status | output | 14 | Sync-status word |
| line_no | output | 10 | Current line |
| dot_no | output | 10 | Current dot within the line |
| field | output | 1 | Odd/even field flag |
| frame_start | output | 1 | One-cycle frame-start pulse |
| in_retrace | output | 1 | High inside the retrace zone |

## Verification
The bench builds the block with BACK_PORCH=2 and FRAME_LINE=3, and programs a raster of 8 lines by 12 dots. It sets a 4-dot horizontal sync, 2 vertical sync lines and a 6-dot front porch. With this raster a full frame lasts under 100 enabled cycles. A model in the bench can then compare every status bit at every dot of several frames, in both interlaced and progressive operation, with a gapped enable pattern. The reset geometry is checked by running a whole default line, and total-register writes are tried both mid-frame and in the same cycle as an enable.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int BACK_PORCH    = 32,
  parameter int FRAME_LINE    = 42,
  parameter int RETRACE_LINES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dot_en,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [13:0] status,
  output logic [9:0]  line_no,
  output logic [9:0]  dot_no,
  output logic        field,
  output logic        frame_start,
  output logic        in_retrace
);
  localparam int CW = 10;
  localparam int XW = CW + 1;

  logic [CW-1:0] lines_m1, dots_m1, fporch_m1;
  logic [3:0]    vsync_n;
  logic [6:0]    hsync_u;
  logic          interlace;

  logic wr_total, eol, eof;
  logic [CW-1:0] next_line, new_lines_m1;

  assign wr_total     = wr_en && (wr_sel == 2'd0);
  assign new_lines_m1 = wr_data[16 +: CW];
  assign eol          = dot_en && (dot_no == dots_m1);
  assign eof          = eol && (line_no == lines_m1);
  assign next_line    = eof ? '0 : line_no + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_m1  <= 10'h270;
      dots_m1   <= 10'h35F;
      vsync_n   <= 4'h5;
      hsync_u   <= 7'h3F;
      fporch_m1 <= '0;
      interlace <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          lines_m1 <= wr_data[16 +: CW];
          dots_m1  <= wr_data[CW-1:0];
        end
        2'd1: begin
          vsync_n <= wr_data[11:8];
          hsync_u <= wr_data[6:0];
        end
        2'd2: interlace <= wr_data[4];
        default: fporch_m1 <= wr_data[CW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_no      <= '0;
      line_no     <= '0;
      field       <= 1'b0;
      frame_start <= 1'b0;
    end else if (wr_total) begin
      dot_no      <= '0;
      line_no     <= (line_no > new_lines_m1) ? new_lines_m1 : line_no;
      frame_start <= 1'b0;
    end else begin
      frame_start <= eol && (next_line == CW'(FRAME_LINE));
      if (dot_en) begin
        if (eol) begin
          dot_no  <= '0;
          line_no <= next_line;
          if (eof && interlace) field <= ~field;
        end else begin
          dot_no <= dot_no + 1'b1;
        end
      end
    end
  end

  logic [XW-1:0] hs_dots, fp_dots, dots_total, dot_x, line_x;
  logic          par, below_vs, s11, s12, s13;

  assign hs_dots    = XW'({hsync_u, 1'b0}) + XW'(2);
  assign fp_dots    = XW'(fporch_m1) + XW'(1);
  assign dots_total = XW'(dots_m1) + XW'(1);
  assign dot_x      = XW'(dot_no);
  assign line_x     = XW'(line_no);
  assign par        = (line_no[0] == field);
  assign below_vs   = (line_x < XW'(vsync_n));

  always_comb begin
    s13 = !below_vs;
    if (par) begin
      s12 = (dot_x >= hs_dots);
      s11 = s13 && (dot_x >= fp_dots);
    end else begin
      s12 = 1'b1;
      s11 = s13 && ((dot_x + XW'(BACK_PORCH)) < dots_total);
    end
  end

  assign status     = {s13, s12, s11, field, line_no};
  assign in_retrace = ((line_x + XW'(RETRACE_LINES)) >= (XW'(lines_m1) + XW'(1)));
endmodule

// File: rtl/raster_timer_checks.sv
module raster_timer_checks #(
  parameter int FRAME_LINE = 42
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dot_en,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [9:0] dot_no,
  input logic [9:0] line_no,
  input logic [9:0] dots_m1,
  input logic [9:0] lines_m1,
  input logic       field,
  input logic       frame_start
);
  a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && !wr_en && dot_no == dots_m1) |=> (dot_no == 10'd0));

  a_r2_dot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dot_en && !wr_en) |=> $stable(dot_no) && $stable(line_no));

  a_r3_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(dot_en && dot_no == dots_m1 && line_no == lines_m1) |=> $stable(field));

  a_r7_frame_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_no == 10'(FRAME_LINE) && dot_no == 10'd0));

  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r9_total_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (dot_no == 10'd0 && line_no <= lines_m1));
endmodule

bind raster_timer raster_timer_checks #(.FRAME_LINE(FRAME_LINE)) u_checks (
  .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .dot_no(dot_no), .line_no(line_no), .dots_m1(dots_m1), .lines_m1(lines_m1),
  .field(field), .frame_start(frame_start)
);

// File: tb/raster_timer_bench.sv
module raster_timer_bench;
  localparam int BP = 2;
  localparam int FL = 3;

  logic clk = 0, rst_n = 0, dot_en = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [13:0] status;
  logic [9:0] line_no, dot_no;
  logic field, frame_start, in_retrace;

  int total = 0, bad = 0;
  int m_lines = 625, m_dots = 864, m_vs = 5, m_hw = 128, m_fp = 1;
  int m_line = 0, m_dot = 0, m_field = 0, m_il = 0, m_pulse = 0;
  bit done = 0;

  raster_timer #(.BACK_PORCH(BP), .FRAME_LINE(FL), .RETRACE_LINES(6)) u_raster_timer (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(status), .line_no(line_no), .dot_no(dot_no),
    .field(field), .frame_start(frame_start), .in_retrace(in_retrace));

  always #4 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h line=%0d dot=%0d", tag, got, exp, m_line, m_dot);
    end
  endtask

  function automatic int exp_status();
    int s12, s13, s11;
    s13 = (m_line >= m_vs);
    if ((m_line & 1) == m_field) begin
      s12 = (m_dot >= m_hw);
      s11 = s13 && (m_dot >= m_fp);
    end else begin
      s12 = 1;
      s11 = s13 && (m_dot < m_dots - BP);
    end
    return (s13 << 13) | (s12 << 12) | (s11 << 11) | (m_field << 10) | m_line;
  endfunction

  task automatic advance();
    m_pulse = 0;
    if (m_dot == m_dots - 1) begin
      m_dot = 0;
      if (m_line == m_lines - 1) begin
        m_line = 0;
        if (m_il != 0) m_field ^= 1;
      end else m_line++;
      m_pulse = (m_line == FL);
    end else m_dot++;
  endtask

  task automatic step(bit en);
    dot_en = en;
    @(posedge clk); #1;
    if (en) advance(); else m_pulse = 0;
    dot_en = 0;
  endtask

  task automatic wr(int sel, int data, bit en);
    wr_en = 1; wr_sel = 2'(sel); wr_data = data; dot_en = en;
    @(posedge clk); #1;
    wr_en = 0; dot_en = 0; m_pulse = 0;
    case (sel)
      0: begin
        m_lines = ((data >> 16) & 10'h3FF) + 1;
        m_dots = (data & 10'h3FF) + 1;
        m_dot = 0;
        if (m_line > m_lines - 1) m_line = m_lines - 1;
      end
      1: begin m_vs = (data >> 8) & 4'hF; m_hw = ((data & 7'h7F) + 1) * 2; end
      2: m_il = (data >> 4) & 1;
      default: m_fp = (data & 10'h3FF) + 1;
    endcase
  endtask

  task automatic full_check(string tag);
    string t;
    t = ((m_line & 1) == m_field) ? "R5" : "R6";
    chk({tag, " ", t, " status"}, status, exp_status());
    chk({tag, " R2 dot"}, dot_no, m_dot);
    chk({tag, " R3 field"}, field, m_field);
    chk({tag, " R7 frame_start"}, frame_start, m_pulse);
    chk({tag, " R8 retrace"}, in_retrace, (m_line >= m_lines - 6));
  endtask

  task automatic sweep(string tag, int cycles);
    for (int i = 0; i < cycles; i++) begin
      step((i % 5) != 2);
      full_check(tag);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen_odd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset status", status, 0);
    chk("R1 reset line", line_no, 0);
    chk("R1 reset field", field, 0);
    chk("R4 reset status line", status[9:0], 0);
    for (int i = 0; i < 864; i++) step(1);
    chk("R1 R2 default line length", line_no, 1);
    chk("R1 R2 dot back to zero", dot_no, 0);
    chk("R1 R6 default status", status, exp_status());
    for (int i = 0; i < 200; i++) step(1);
    chk("R1 R5 R6 default status later", status, exp_status());

    wr(0, (7 << 16) | 11, 0);
    chk("R9 R10 total write line clamp", line_no, m_line);
    chk("R9 total write dot", dot_no, 0);
    wr(1, (2 << 8) | 1, 0);
    wr(3, 5, 0);
    wr(2, 32'h10, 0);
    chk("R10 R4 status after setup", status, exp_status());

    sweep("interlaced", 300);
    seen_odd = m_field;
    sweep("interlaced2", 150);
    chk("R3 field toggles", (seen_odd != m_field) || (m_field == 1) || (m_line < 8), 1);

    wr(2, 32'h0, 0);
    sweep("progressive", 300);

    wr(2, 32'h10, 0);
    wr(1, (5 << 8) | 0, 0);
    wr(3, 1, 0);
    sweep("altsync", 250);

    while (m_line != 6) step(1);
    step(1);
    wr(0, (3 << 16) | 11, 0);
    chk("R9 line saturated", line_no, 3);
    chk("R9 dot cleared", dot_no, 0);
    full_check("after shrink");
    while (m_dot != 5) step(1);
    wr(0, (7 << 16) | 11, 1);
    chk("R9 write beats dot_en", dot_no, 0);
    chk("R9 write keeps line", line_no, m_line);
    sweep("regrow", 200);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule